// File: doc/BRIEF.md
# Receive FIFO with RTS Hysteresis

This block is the receive-side byte queue of a serial port. A deserializer hands it bytes through a write strobe, and a register-read path takes them out through a pop strobe. The block keeps a 6-bit fill count and reports it. It also gives empty, full, upper-threshold and lower-threshold flags, plus a sticky pointer-error flag. A clear command empties the queue in one cycle.

The block can also drive the request-to-send line from its own fill count. Two programmable limits set a hysteresis band. When the count reaches the upper limit, the line goes high and the far end must pause. When the count falls to the lower limit, the line goes low and the far end may send again. Inside the band the line keeps its last value. When the flow-control enable is off, the line simply repeats a legacy request-to-send input. The lower limit is meant to be no greater than the upper one.

Top module: `rx_flow_fifo`

## Requirements
- R1: After reset the fill count is 0, `flagEmpty` is 1, `ptrErr` is 0, `popData` is 0 and the internal flow-control state is low.
- R2: A write while the queue is not full stores the byte and raises `level` by one in the next cycle. Bytes leave in the order they were written.
- R3: A pop while the queue is not empty lowers `level` by one. The oldest byte appears on `popData` in the cycle after the pop, and `popData` holds that value until the next pop.
- R4: A write and a pop in the same cycle on a non-empty queue leave `level` unchanged. This also holds when the queue is full: the pop frees a slot and the write is kept.
- R5: A write to a full queue with no pop in the same cycle discards the byte, leaves `level` unchanged and sets `ptrErr`. `ptrErr` stays set until a clear.
- R6: A pop from an empty queue sets `ptrErr` and puts 0 on `popData`. A write in that same cycle is still stored.
- R7: `clearReq` takes priority over writes and pops in the same cycle. In the next cycle `level` is 0, the stored bytes are gone, `ptrErr` is 0 and the flow-control state is low, unless `hiThresh` is 0.
- R8: `flagEmpty` is set exactly when `level` is 0. `flagFull` is set exactly when `level` equals DEPTH (32 by default). `flagThrHi` is set when `level` >= `hiThresh`. `flagThrLo` is set when `level` <= `loThresh`.
- R9: With `rtsCtrlEn` = 1, `rtsOut` is 1 in every cycle where `level` >= `hiThresh`. This check is applied first, so it wins when the limits overlap.
- R10: With `rtsCtrlEn` = 1, `rtsOut` is 0 in every cycle where `level` <= `loThresh` and `level` < `hiThresh`.
- R11: With `rtsCtrlEn` = 1 and `level` strictly between the two limits, `rtsOut` keeps its value from the previous cycle.
- R12: With `rtsCtrlEn` = 0, `rtsOut` equals `legacyRts`. The hysteresis state keeps tracking the fill count, so when the enable returns, `rtsOut` reflects the current fill count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Byte from the receiver is valid this cycle |
| wrData | input | 8 | Received byte |
| popReq | input | 1 | Read request from the register path |
| clearReq | input | 1 | Empty the queue and clear the error flag |
| rtsCtrlEn | input | 1 | Let the fill count drive request-to-send |
| legacyRts | input | 1 | Request-to-send value used when the enable is off |
| hiThresh | input | 6 | Upper limit: at or above it, the line goes high |
| loThresh | input | 6 | Lower limit: at or below it, the line goes low |
| popData | output | 8 | Byte from the last pop (0 after a pop from an empty queue) |
| level | output | 6 | Number of stored bytes |
| flagEmpty | output | 1 | Queue empty |
| flagFull | output | 1 | Queue full |
| flagThrHi | output | 1 | Fill count at or above the upper limit |
| flagThrLo | output | 1 | Fill count at or below the lower limit |
| ptrErr | output | 1 | Sticky overflow/underflow error |
| rtsOut | output | 1 | Request-to-send line |

## Verification
The two functions that can collide are the receiver write and the register pop. The bench asserts both in the same cycle in three states: a partly filled queue, where the count must hold; a full queue, where the write must survive because the pop frees a slot; and an empty queue, where the pop reports an error and returns zero while the write is kept. A scoreboard queue follows each byte, so any byte lost or misordered in these collisions shows up on a later pop. The per-cycle model of `level`, `ptrErr` and `rtsOut` judges the count and error effects in the cycle right after each collision.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LVL_W  = 6;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic doWrite;
    logic doPop;
    logic popEmpty;
    logic doClear;
  } rxqStrobes_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rxq_pkg::rxqStrobes_t      strb,
  input  logic [rxq_pkg::BYTE_W-1:0] wrData,
  output logic [rxq_pkg::BYTE_W-1:0] popData
);
  import rxq_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.doWrite && !strb.doClear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.doClear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.doWrite) wrPtr <= bump(wrPtr);
      if (strb.doPop)   rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              popData <= '0;
    else if (strb.doPop)    popData <= mem[rdPtr];
    else if (strb.popEmpty) popData <= '0;
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic                       popReq,
  input  logic                       clearReq,
  input  logic                       rtsCtrlEn,
  input  logic                       legacyRts,
  input  logic [rxq_pkg::LVL_W-1:0]  hiThresh,
  input  logic [rxq_pkg::LVL_W-1:0]  loThresh,
  output rxq_pkg::rxqStrobes_t       strb,
  output logic [rxq_pkg::LVL_W-1:0]  level,
  output logic                       flagEmpty,
  output logic                       flagFull,
  output logic                       flagThrHi,
  output logic                       flagThrLo,
  output logic                       ptrErr,
  output logic                       rtsOut
);
  import rxq_pkg::*;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic accWr, accPop, errWr, errPop;
  logic rtsHeld, rtsNow;

  assign flagEmpty = (level == '0);
  assign flagFull  = (level == FULL_LVL);
  assign flagThrHi = (level >= hiThresh);
  assign flagThrLo = (level <= loThresh);

  always_comb begin
    accWr  = wrValid && (!flagFull || popReq) && !clearReq;
    accPop = popReq && !flagEmpty && !clearReq;
    errPop = popReq && flagEmpty && !clearReq;
    errWr  = wrValid && flagFull && !popReq && !clearReq;
    strb.doWrite  = accWr;
    strb.doPop    = accPop;
    strb.popEmpty = errPop;
    strb.doClear  = clearReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearReq) level <= '0;
    else if (accWr && !accPop) level <= level + 1'b1;
    else if (accPop && !accWr) level <= level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearReq)  ptrErr <= 1'b0;
    else if (errWr || errPop) ptrErr <= 1'b1;
  end

  always_comb begin
    if (flagThrHi)      rtsNow = 1'b1;
    else if (flagThrLo) rtsNow = 1'b0;
    else                rtsNow = rtsHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearReq) rtsHeld <= 1'b0;
    else                   rtsHeld <= rtsNow;
  end

  assign rtsOut = rtsCtrlEn ? rtsNow : legacyRts;
endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       popReq,
  input  logic       clearReq,
  input  logic       rtsCtrlEn,
  input  logic       legacyRts,
  input  logic [5:0] hiThresh,
  input  logic [5:0] loThresh,
  output logic [7:0] popData,
  output logic [5:0] level,
  output logic       flagEmpty,
  output logic       flagFull,
  output logic       flagThrHi,
  output logic       flagThrLo,
  output logic       ptrErr,
  output logic       rtsOut
);
  rxq_pkg::rxqStrobes_t strb;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .popReq(popReq),
    .clearReq(clearReq), .rtsCtrlEn(rtsCtrlEn), .legacyRts(legacyRts),
    .hiThresh(hiThresh), .loThresh(loThresh), .strb(strb), .level(level),
    .flagEmpty(flagEmpty), .flagFull(flagFull), .flagThrHi(flagThrHi),
    .flagThrLo(flagThrLo), .ptrErr(ptrErr), .rtsOut(rtsOut)
  );

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .popData(popData)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic [7:0] wrData,
  input logic       popReq,
  input logic       clearReq,
  input logic       rtsCtrlEn,
  input logic       legacyRts,
  input logic [5:0] hiThresh,
  input logic [5:0] loThresh,
  input logic [7:0] popData,
  input logic [5:0] level,
  input logic       flagEmpty,
  input logic       flagFull,
  input logic       flagThrHi,
  input logic       flagThrLo,
  input logic       ptrErr,
  input logic       rtsOut
);
  a_r2_write_grows: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !popReq && !clearReq && !flagFull |=> level == $past(level) + 6'd1);

  a_r4_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && popReq && !clearReq && !flagEmpty |=> level == $past(level));

  a_r5_overflow_err: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && flagFull && !popReq && !clearReq |=> ptrErr && level == $past(level));

  a_r6_underflow_zero: assert property (@(posedge clk) disable iff (!rstN)
    popReq && flagEmpty && !clearReq |=> ptrErr && popData == 8'd0);

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> flagEmpty && !ptrErr);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagEmpty, flagFull}));

  a_r9_rts_high: assert property (@(posedge clk) disable iff (!rstN)
    rtsCtrlEn && flagThrHi |-> rtsOut);

  a_r10_rts_low: assert property (@(posedge clk) disable iff (!rstN)
    rtsCtrlEn && flagThrLo && !flagThrHi |-> !rtsOut);

  a_r11_rts_hold: assert property (@(posedge clk) disable iff (!rstN)
    rtsCtrlEn && $past(rtsCtrlEn) && $past(rstN) && !$past(clearReq)
    && !flagThrHi && !flagThrLo |-> rtsOut == $past(rtsOut));
endmodule

bind rx_flow_fifo rxq_checker #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/rx_flow_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_flow_fifo_tb_top;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, popReq = 1'b0, clearReq = 1'b0;
  logic rtsCtrlEn = 1'b1, legacyRts = 1'b0;
  logic [7:0] wrData = '0;
  logic [5:0] hiThresh = 6'd12, loThresh = 6'd4;
  logic [7:0] popData;
  logic [5:0] level;
  logic flagEmpty, flagFull, flagThrHi, flagThrLo, ptrErr, rtsOut;

  int checks = 0, fails = 0;
  bit finished = 0;

  byte unsigned sbQ[$];
  int mLevel = 0;
  bit mErr = 0, mRts = 0;
  logic [7:0] mPop = 0;

  always #10 clk = ~clk;

  rx_flow_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit expRts;
    chk("R2/R3 level", level, mLevel);
    chk("R8 empty", flagEmpty, mLevel == 0);
    chk("R8 full", flagFull, mLevel == DEPTH);
    chk("R8 thrHi", flagThrHi, mLevel >= hiThresh);
    chk("R8 thrLo", flagThrLo, mLevel <= loThresh);
    chk("R5/R6 ptrErr", ptrErr, mErr);
    chk("R3 popData scoreboard", popData, mPop);
    if (mLevel >= hiThresh) mRts = 1;
    else if (mLevel <= loThresh) mRts = 0;
    expRts = rtsCtrlEn ? mRts : legacyRts;
    chk(rtsCtrlEn ? "R9/R10/R11 rts" : "R12 legacy rts", rtsOut, expRts);
  endtask

  // one cycle: drive on negedge, sample 1 ns after the rising edge
  task automatic step(input bit wr, input byte unsigned d, input bit pop, input bit clr);
    bit accPop, accWr;
    @(negedge clk);
    wrValid = wr; wrData = d; popReq = pop; clearReq = clr;
    @(posedge clk);
    #1;
    wrValid = 0; popReq = 0; clearReq = 0;
    if (clr) begin
      sbQ.delete(); mLevel = 0; mErr = 0; mRts = 0;
    end else begin
      accPop = pop && mLevel > 0;
      accWr  = wr && (mLevel < DEPTH || pop);
      if (pop && mLevel == 0) begin mErr = 1; mPop = 0; end
      if (wr && mLevel == DEPTH && !pop) mErr = 1;
      if (accPop) begin mPop = sbQ.pop_front(); mLevel--; end
      if (accWr) begin sbQ.push_back(d); mLevel++; end
    end
    checkAll();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 empty", flagEmpty, 1);
    chk("R1 ptrErr", ptrErr, 0);
    chk("R1 popData", popData, 0);
    chk("R1 rts", rtsOut, 0);
    @(negedge clk); rstN = 1;
    // R2 fill past the upper limit: RTS rises at 12 (R9)
    for (int i = 0; i < 16; i++) step(1, 8'hA0 + i, 0, 0);
    // R3 drain into the band: RTS holds high (R11), falls at 4 (R10)
    for (int i = 0; i < 12; i++) step(0, 0, 1, 0);
    // R4 simultaneous write and pop on a partial queue
    for (int i = 0; i < 5; i++) step(1, 8'h50 + i, 1, 0);
    // fill to full, then overflow (R5)
    while (mLevel < DEPTH) step(1, 8'h10 + mLevel, 0, 0);
    step(1, 8'hEE, 0, 0);
    step(1, 8'hEF, 0, 0);
    // R4 full queue: write with pop is kept
    step(1, 8'h77, 1, 0);
    // R7 clear together with write and pop
    step(1, 8'h99, 1, 1);
    // R6 pop empty returns zero, then pop+write on empty
    step(0, 0, 1, 0);
    step(1, 8'h3C, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    // R12 legacy path while the count crosses the upper limit
    rtsCtrlEn = 0;
    legacyRts = 1;
    for (int i = 0; i < 13; i++) step(1, 8'hC0 + i, 0, 0);
    legacyRts = 0;
    step(0, 0, 0, 0);
    rtsCtrlEn = 1;
    step(0, 0, 0, 0);
    // overlapping limits: upper wins (R9), then equal limits
    hiThresh = 6'd8; loThresh = 6'd10;
    step(0, 0, 1, 0);
    hiThresh = 6'd6; loThresh = 6'd6;
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0);
    while (mLevel > 0) step(0, 0, 1, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule